// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This block is the combinational datapath that an 8-bit processor core uses for its bit-manipulation instruction group. It takes one operand byte, a bit index, an operation code, a flag that marks the short accumulator-only rotate forms, and the current condition flags. In the same cycle it returns the result byte, a write-back enable, and the condition flags to be stored next.

The unit covers circular and through-carry rotates in both directions, a left shift that fills with zero, arithmetic and logical right shifts, a nibble exchange, and single-bit test, clear and set. Instruction decoding and any read-modify-write memory sequence belong to the surrounding core. Flags travel as a 4-bit vector: bit 3 is Z (zero), bit 2 is N (subtract), bit 1 is H (half carry) and bit 0 is C (carry).

Top module: `rsb_unit`

## Requirements
- R1: Circular rotates: op code 0 rotates left, placing old bit 7 in both bit 0 and C. Op code 1 rotates right, placing old bit 0 in both bit 7 and C.
- R2: Rotates through carry: op code 2 shifts left with the incoming C entering bit 0 and old bit 7 going to C. Op code 3 shifts right with the incoming C entering bit 7 and old bit 0 going to C.
- R3: Op code 4 shifts left, puts zero into bit 0 and moves old bit 7 into C.
- R4: Op code 5 shifts right, keeps bit 7 and moves old bit 0 into C. Op code 6 shifts right, puts zero into bit 7 and moves old bit 0 into C.
- R5: Op code 7 exchanges the upper and lower nibbles and clears C.
- R6: For op codes 0 to 7, N and H are cleared, Z is set exactly when the result is zero (unless R7 applies), and the write-enable is 1.
- R7: When the accumulator-form input is 1, op codes 0 to 3 drive Z to 0 whatever the result. For every other op code this input has no effect.
- R8: Op code 8 tests the bit selected by the index (index 0 is the least significant bit). Z is set when that bit is 0, N is cleared, H is set, and C is left unchanged. The write-enable is 0 and the result equals the operand.
- R9: Op code 9 clears the indexed bit and op code 10 sets it (index 0 is the least significant bit). All other bits and all four flags are unchanged, and the write-enable is 1.
- R10: Op codes 11 to 15 are not used. For them the result equals the operand, the flags equal the incoming flags, and the write-enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 | Operand byte |
| bit_idx_i | input | 3 | Bit index for test, clear and set |
| op_sel_i | input | 4 | Operation code (0 to 10 defined) |
| acc_form_i | input | 1 | Marks the accumulator-only rotate form |
| flags_i | input | 4 | Incoming flags {Z,N,H,C} |
| result_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Result should be written back |
| flags_o | output | 4 | Next flags {Z,N,H,C} |

## Verification
The assertions inside the top module check these rules whenever an input changes: the N and H clearing on the shift group, the cleared carry after a swap, a Z of 0 for accumulator-form rotates, and bit test leaving C, the result and the write-back untouched. They also check that bit clear and bit set keep every flag and differ from the operand in at most one bit. Only the bench's scenarios show the exact bit movement of each rotate and shift, the carry chain of the through-carry forms, the bit positions selected by the index, and the pass-through behaviour of the unused op codes.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_RLC  = 4'd0,
    OP_RRC  = 4'd1,
    OP_RL   = 4'd2,
    OP_RR   = 4'd3,
    OP_SLA  = 4'd4,
    OP_SRA  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SWAP = 4'd7,
    OP_BTST = 4'd8,
    OP_BCLR = 4'd9,
    OP_BSET = 4'd10
  } rsb_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } rsb_flags_t;

endpackage

// File: rtl/rsb_shift_path.sv
module rsb_shift_path
  import rsb_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  rsb_op_e          op_i,
  input  logic [W-1:0]     opnd_i,
  input  logic             c_in_i,
  input  logic             acc_form_i,
  output logic [W-1:0]     res_o,
  output rsb_flags_t       flags_o
);

  localparam int unsigned HALF = W / 2;

  logic [W-1:0] res_d;
  logic         c_d;
  logic         is_rot;

  always_comb begin
    res_d = opnd_i;
    c_d   = 1'b0;
    case (op_i)
      OP_RLC: begin
        res_d = {opnd_i[W-2:0], opnd_i[W-1]};
        c_d   = opnd_i[W-1];
      end
      OP_RRC: begin
        res_d = {opnd_i[0], opnd_i[W-1:1]};
        c_d   = opnd_i[0];
      end
      OP_RL: begin
        res_d = {opnd_i[W-2:0], c_in_i};
        c_d   = opnd_i[W-1];
      end
      OP_RR: begin
        res_d = {c_in_i, opnd_i[W-1:1]};
        c_d   = opnd_i[0];
      end
      OP_SLA: begin
        res_d = {opnd_i[W-2:0], 1'b0};
        c_d   = opnd_i[W-1];
      end
      OP_SRA: begin
        res_d = {opnd_i[W-1], opnd_i[W-1:1]};
        c_d   = opnd_i[0];
      end
      OP_SRL: begin
        res_d = {1'b0, opnd_i[W-1:1]};
        c_d   = opnd_i[0];
      end
      OP_SWAP: begin
        res_d = {opnd_i[HALF-1:0], opnd_i[W-1:HALF]};
        c_d   = 1'b0;
      end
      default: begin
        res_d = opnd_i;
        c_d   = c_in_i;
      end
    endcase
  end

  assign is_rot = (op_i == OP_RLC) || (op_i == OP_RRC) ||
                  (op_i == OP_RL)  || (op_i == OP_RR);

  always_comb begin
    res_o     = res_d;
    flags_o.z = (is_rot && acc_form_i) ? 1'b0 : ~|res_d;
    flags_o.n = 1'b0;
    flags_o.h = 1'b0;
    flags_o.c = c_d;
  end

endmodule

// File: rtl/rsb_bit_path.sv
module rsb_bit_path
  import rsb_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  rsb_op_e          op_i,
  input  logic [W-1:0]     opnd_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [W-1:0]     res_o,
  output logic             test_z_o
);

  logic [W-1:0] sel_mask;

  generate
    for (genvar g = 0; g < W; g++) begin : g_mask
      assign sel_mask[g] = (idx_i == IDX_W'(g));
    end
  endgenerate

  assign test_z_o = ~|(opnd_i & sel_mask);

  always_comb begin
    case (op_i)
      OP_BCLR: res_o = opnd_i & ~sel_mask;
      OP_BSET: res_o = opnd_i | sel_mask;
      default: res_o = opnd_i;
    endcase
  end

endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     opnd_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic [OP_W-1:0]  op_sel_i,
  input  logic             acc_form_i,
  input  logic [3:0]       flags_i,
  output logic [W-1:0]     result_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_o
);

  rsb_op_e    op;
  rsb_flags_t fl_in;
  rsb_flags_t fl_out;
  rsb_flags_t sh_flags;
  logic [W-1:0] sh_res;
  logic [W-1:0] bit_res;
  logic         bit_z;

  assign op    = rsb_op_e'(op_sel_i);
  assign fl_in = rsb_flags_t'(flags_i);

  rsb_shift_path #(.W(W)) i_shift (
    .op_i       (op),
    .opnd_i     (opnd_i),
    .c_in_i     (fl_in.c),
    .acc_form_i (acc_form_i),
    .res_o      (sh_res),
    .flags_o    (sh_flags)
  );

  rsb_bit_path #(.W(W), .IDX_W(IDX_W)) i_bit (
    .op_i     (op),
    .opnd_i   (opnd_i),
    .idx_i    (bit_idx_i),
    .res_o    (bit_res),
    .test_z_o (bit_z)
  );

  always_comb begin
    result_o = opnd_i;
    wr_en_o  = 1'b0;
    fl_out   = fl_in;
    case (op)
      OP_RLC, OP_RRC, OP_RL, OP_RR,
      OP_SLA, OP_SRA, OP_SRL, OP_SWAP: begin
        result_o = sh_res;
        wr_en_o  = 1'b1;
        fl_out   = sh_flags;
      end
      OP_BTST: begin
        fl_out.z = bit_z;
        fl_out.n = 1'b0;
        fl_out.h = 1'b1;
      end
      OP_BCLR, OP_BSET: begin
        result_o = bit_res;
        wr_en_o  = 1'b1;
      end
      default: ;
    endcase
  end

  assign flags_o = fl_out;

  always_comb begin
    if (op_sel_i <= OP_W'(OP_SWAP)) begin
      // R6
      shift_nh_clear_chk: assert (flags_o[2] == 1'b0 && flags_o[1] == 1'b0 && wr_en_o);
    end
    if (op_sel_i == OP_W'(OP_SWAP)) begin
      // R5
      swap_c_clear_chk: assert (flags_o[0] == 1'b0);
    end
    if (acc_form_i && op_sel_i <= OP_W'(OP_RR)) begin
      // R7
      acc_rot_z_chk: assert (flags_o[3] == 1'b0);
    end
    if (op_sel_i == OP_W'(OP_BTST)) begin
      // R8
      bit_test_keep_chk: assert (!wr_en_o && flags_o[0] == flags_i[0] && result_o == opnd_i);
    end
    if (op_sel_i == OP_W'(OP_BCLR) || op_sel_i == OP_W'(OP_BSET)) begin
      // R9
      bit_edit_flags_chk: assert (flags_o == flags_i && $countones(result_o ^ opnd_i) <= 1);
    end
  end

endmodule

// File: tb/test_rsb_unit.sv
module test_rsb_unit;

  logic       clk;
  logic       rst_n;
  logic [7:0] opnd;
  logic [2:0] idx;
  logic [3:0] op;
  logic       acc;
  logic [3:0] fl;
  logic [7:0] res;
  logic       wr;
  logic [3:0] flo;

  int n_checks;
  int n_fail;

  rsb_unit i_rsb_unit (
    .opnd_i     (opnd),
    .bit_idx_i  (idx),
    .op_sel_i   (op),
    .acc_form_i (acc),
    .flags_i    (fl),
    .result_o   (res),
    .wr_en_o    (wr),
    .flags_o    (flo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    opnd = 8'h00; idx = 3'd0; op = 4'd15; acc = 1'b0; fl = 4'h0;
  end

  task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [2:0] i,
                       input logic ac, input logic [3:0] f);
    @(negedge clk);
    op = o; opnd = a; idx = i; acc = ac; fl = f;
    #2;
  endtask

  task automatic expect_out(input string tag, input logic [7:0] er,
                            input logic ew, input logic [3:0] ef);
    n_checks++;
    if (res !== er || wr !== ew || flo !== ef) begin
      n_fail++;
      $display("FAIL %s: got res=%h wr=%b fl=%h, expected res=%h wr=%b fl=%h",
               tag, res, wr, flo, er, ew, ef);
    end
  endtask

  // Independent reference written from the requirements: {wr, flags, result}
  function automatic logic [12:0] model(input logic [3:0] o, input logic [7:0] a,
                                        input logic [2:0] i, input logic ac,
                                        input logic [3:0] f);
    logic [7:0] r;
    logic c;
    logic [3:0] nf;
    logic w;
    r = a; c = f[0]; nf = f; w = 1'b0;
    if (o <= 4'd7) begin
      case (o)
        4'd0: begin c = a[7]; r = (a << 1) | {7'd0, a[7]}; end
        4'd1: begin c = a[0]; r = (a >> 1) | {a[0], 7'd0}; end
        4'd2: begin c = a[7]; r = (a << 1) | {7'd0, f[0]}; end
        4'd3: begin c = a[0]; r = (a >> 1) | {f[0], 7'd0}; end
        4'd4: begin c = a[7]; r = a << 1; end
        4'd5: begin c = a[0]; r = (a >> 1) | (a & 8'h80); end
        4'd6: begin c = a[0]; r = a >> 1; end
        default: begin c = 1'b0; r = {a[3:0], a[7:4]}; end
      endcase
      nf = {(ac && o <= 4'd3) ? 1'b0 : (r == 8'd0), 1'b0, 1'b0, c};
      w = 1'b1;
    end else if (o == 4'd8) begin
      nf = {~a[i], 1'b0, 1'b1, f[0]};
    end else if (o == 4'd9) begin
      r = a & ~(8'd1 << i); w = 1'b1;
    end else if (o == 4'd10) begin
      r = a | (8'd1 << i); w = 1'b1;
    end
    return {w, nf, r};
  endfunction

  task automatic t_reset_state;
    apply(4'd15, 8'h00, 3'd0, 1'b0, 4'h0);
    expect_out("R10 idle after reset", 8'h00, 1'b0, 4'h0);
  endtask

  task automatic t_circular;
    apply(4'd0, 8'h85, 3'd0, 1'b0, 4'h0);
    expect_out("R1 rotate-left circular", 8'h0B, 1'b1, 4'h1);
    apply(4'd1, 8'h01, 3'd0, 1'b0, 4'h0);
    expect_out("R1 rotate-right circular", 8'h80, 1'b1, 4'h1);
  endtask

  task automatic t_through_carry;
    apply(4'd2, 8'h80, 3'd0, 1'b0, 4'h0);
    expect_out("R2 rotate-left through C to zero", 8'h00, 1'b1, 4'h9);
    apply(4'd3, 8'h01, 3'd0, 1'b0, 4'h1);
    expect_out("R2 rotate-right through C", 8'h80, 1'b1, 4'h1);
  endtask

  task automatic t_shifts;
    apply(4'd4, 8'hFF, 3'd0, 1'b0, 4'h6);
    expect_out("R3 left shift clears N,H", 8'hFE, 1'b1, 4'h1);
    apply(4'd5, 8'h81, 3'd0, 1'b0, 4'h0);
    expect_out("R4 arithmetic right", 8'hC0, 1'b1, 4'h1);
    apply(4'd6, 8'h81, 3'd0, 1'b0, 4'h0);
    expect_out("R4 logical right", 8'h40, 1'b1, 4'h1);
    apply(4'd6, 8'h01, 3'd0, 1'b0, 4'h0);
    expect_out("R6 logical right to zero sets Z", 8'h00, 1'b1, 4'h9);
  endtask

  task automatic t_swap;
    apply(4'd7, 8'hA5, 3'd0, 1'b0, 4'h1);
    expect_out("R5 swap clears C", 8'h5A, 1'b1, 4'h0);
    apply(4'd7, 8'h00, 3'd0, 1'b1, 4'h7);
    expect_out("R7 acc form ignored on swap", 8'h00, 1'b1, 4'h8);
  endtask

  task automatic t_acc_form;
    apply(4'd2, 8'h80, 3'd0, 1'b1, 4'h0);
    expect_out("R7 acc rotate forces Z=0", 8'h00, 1'b1, 4'h1);
    apply(4'd4, 8'h80, 3'd0, 1'b1, 4'h0);
    expect_out("R7 acc flag ignored on left shift", 8'h00, 1'b1, 4'h9);
  endtask

  task automatic t_bit_test;
    apply(4'd8, 8'h7F, 3'd7, 1'b0, 4'h1);
    expect_out("R8 test clear bit7 keeps C", 8'h7F, 1'b0, 4'hB);
    apply(4'd8, 8'h01, 3'd0, 1'b0, 4'h0);
    expect_out("R8 test set bit0", 8'h01, 1'b0, 4'h2);
  endtask

  task automatic t_bit_edit;
    apply(4'd9, 8'hFF, 3'd3, 1'b0, 4'h5);
    expect_out("R9 clear bit3", 8'hF7, 1'b1, 4'h5);
    apply(4'd10, 8'h00, 3'd0, 1'b0, 4'hA);
    expect_out("R9 set bit0", 8'h01, 1'b1, 4'hA);
  endtask

  task automatic t_unused;
    apply(4'd11, 8'h3C, 3'd2, 1'b1, 4'hF);
    expect_out("R10 unused code passes through", 8'h3C, 1'b0, 4'hF);
  endtask

  task automatic t_sweep;
    logic [12:0] e;
    for (int o = 0; o < 16; o++) begin
      for (int k = 0; k < 12; k++) begin
        logic [7:0] a;
        a = 8'((k * 37 + o * 11) ^ (k << 4));
        apply(4'(o), a, 3'(k), k[0], 4'(k + o));
        e = model(4'(o), a, 3'(k), k[0], 4'(k + o));
        expect_out("R1..R10 sweep", e[7:0], e[12], e[11:8]);
      end
    end
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_circular();
    t_through_carry();
    t_shifts();
    t_swap();
    t_acc_form();
    t_bit_test();
    t_bit_edit();
    t_unused();
    t_sweep();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule